// File: doc/BRIEF.md
# Barrel Shift Unit with Flag Generation

This block shifts or rotates a 32-bit operand and produces the new condition flags that an execute stage writes back. Three operations are offered: logical shift left, arithmetic shift right and rotate right. The shift amount is taken either from a register value (`AMT_W` bits wide) or from a short immediate field. Alongside the result the unit produces negative, zero, carry and overflow flags, a range-error flag and a write-enable. The write-enable tells the consumer whether the result and flags may be committed.

The carry is the last bit moved out of the operand. A zero-amount shift leaves the incoming carry untouched. Each operation has its own legal range for register-supplied amounts. A request outside that range raises the error flag and leaves the result and flags uncommitted.

The datapath is combinational. The parameter `OUT_REG` selects whether the outputs leave through a register stage (1, the default) or straight from the logic (0). The block has no control states. Its only sequential element is the optional output stage. That stage has two conditions: idle (`wr_o` low) and committed (`wr_o` high for the cycle after an accepted request).

Top module: `shf_unit`

## Requirements
- R1: Operation code 0 (shift left) gives the low 32 bits of the operand shifted left by the amount. C is the bit that would land at position 32.
- R2: Operation code 1 (arithmetic shift right) fills the vacated upper bits with operand bit 31, and C is operand bit (amount − 1). An amount of 32 yields 32 copies of the sign bit, with C equal to operand bit 31.
- R3: Operation code 2 (rotate right) rotates by the amount modulo 32, and C is the last bit rotated out. A nonzero multiple of 32 returns the operand unchanged, with C equal to operand bit 31.
- R4: An amount of zero returns the operand unchanged and passes the incoming carry `c_in_i` through to `c_o`.
- R5: N equals result bit 31, Z is high exactly when the result is zero, and V is always low.
- R6: With `amt_sel_i`=1 (register source), a shift-left amount above 31 or an arithmetic-shift-right amount above 32 raises `err_o`. Immediate amounts (`amt_sel_i`=0, 5 bits) and rotate amounts never raise it.
- R7: Operation code 3 is reserved and always raises `err_o`.
- R8: When `err_o` is raised, `wr_o` is low. With `OUT_REG`=1 the result and flag outputs keep their previous values.
- R9: With `OUT_REG`=1, the outputs of a request accepted with `in_valid_i` high appear one clock later, and `wr_o` is high for that one cycle only. With `OUT_REG`=0 they appear in the same cycle, and when idle or in error the result is 0, N and Z are low and C equals `c_in_i`.
- R10: Under active-low reset the registered outputs are zero and `wr_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 shift left, 1 arithmetic shift right, 2 rotate right, 3 reserved |
| amt_sel_i | input | 1 | 1 selects the register amount, 0 selects the immediate |
| amt_reg_i | input | AMT_W | Register-supplied amount |
| amt_imm_i | input | 5 | Immediate amount |
| opnd_i | input | DATA_W | Operand |
| c_in_i | input | 1 | Current carry flag |
| res_o | output | DATA_W | Result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag, always low |
| err_o | output | 1 | Range error |
| wr_o | output | 1 | Commit enable for result and flags |

## Verification
The assertions check several things on every cycle:
- Out-of-range register amounts and the reserved code raise the error.
- Error and commit are never high together.
- A held result does not move while an error is shown.
- A zero amount returns the old carry.
- N and Z agree with any committed result.

Only the bench's scenarios can show that the result values and carry bits are right. The bench sweeps every amount from 0 to 33 over several operands for each operation. It also covers the sign fill at 32, rotation by multiples of 32, and the same-cycle behaviour of the unregistered variant.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LSL = 2'd0,
        SHF_ASR = 2'd1,
        SHF_ROR = 2'd2,
        SHF_RSV = 2'd3
    } shf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } shf_flags_t;

endpackage

// File: rtl/shf_lsl.sv
module shf_lsl #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    // One guard bit above the operand catches the last bit pushed out.
    logic [DATA_W:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} << amt_i;
        res_o  = wide[DATA_W-1:0];
        cout_o = wide[DATA_W];
    end
endmodule

// File: rtl/shf_asr.sv
module shf_asr #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    // A guard bit below the operand receives the last bit shifted out.
    // A full-width shift leaves only sign copies, carry included.
    logic [DATA_W:0] ext;

    always_comb begin
        ext    = $unsigned($signed({a_i, 1'b0}) >>> amt_i);
        res_o  = ext[DATA_W:1];
        cout_o = ext[0];
    end
endmodule

// File: rtl/shf_ror.sv
module shf_ror #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [2*DATA_W-1:0] dbl;
    logic [SH_W-1:0]     rot;

    always_comb begin
        rot    = amt_i[SH_W-1:0];
        dbl    = {a_i, a_i} >> rot;
        res_o  = dbl[DATA_W-1:0];
        // The last bit rotated out always ends at the top position.
        cout_o = dbl[DATA_W-1];
    end
endmodule

// File: rtl/shf_range_chk.sv
module shf_range_chk
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  shf_op_e          op_i,
    input  logic             amt_sel_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic             err_o
);
    localparam logic [AMT_W-1:0] LSL_MAX = AMT_W'(DATA_W - 1);
    localparam logic [AMT_W-1:0] ASR_MAX = AMT_W'(DATA_W);

    always_comb begin
        unique case (op_i)
            SHF_LSL: err_o = amt_sel_i && (amt_i > LSL_MAX);
            SHF_ASR: err_o = amt_sel_i && (amt_i > ASR_MAX);
            SHF_ROR: err_o = 1'b0;
            SHF_RSV: err_o = 1'b1;
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [1:0]        op_i,
    input  logic              amt_sel_i,
    input  logic [AMT_W-1:0]  amt_reg_i,
    input  logic [SH_W-1:0]   amt_imm_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              c_in_i,
    output logic [DATA_W-1:0] res_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o,
    output logic              err_o,
    output logic              wr_o
);
    shf_op_e           op;
    logic [AMT_W-1:0]  amt;
    logic              amt_zero;
    logic [DATA_W-1:0] lsl_res, asr_res, ror_res, res_n;
    logic              lsl_c, asr_c, ror_c, cout_n;
    logic              range_err, upd, errv;
    shf_flags_t        flags_n;

    assign op       = shf_op_e'(op_i);
    assign amt      = amt_sel_i ? amt_reg_i : {{(AMT_W-SH_W){1'b0}}, amt_imm_i};
    assign amt_zero = (amt == '0);

    shf_lsl #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lsl (
        .a_i(opnd_i), .amt_i(amt), .res_o(lsl_res), .cout_o(lsl_c));
    shf_asr #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_asr (
        .a_i(opnd_i), .amt_i(amt), .res_o(asr_res), .cout_o(asr_c));
    shf_ror #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_ror (
        .a_i(opnd_i), .amt_i(amt), .res_o(ror_res), .cout_o(ror_c));
    shf_range_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rng (
        .op_i(op), .amt_sel_i(amt_sel_i), .amt_i(amt), .err_o(range_err));

    always_comb begin
        unique case (op)
            SHF_LSL: begin res_n = lsl_res; cout_n = lsl_c; end
            SHF_ASR: begin res_n = asr_res; cout_n = asr_c; end
            SHF_ROR: begin res_n = ror_res; cout_n = ror_c; end
            default: begin res_n = '0;      cout_n = 1'b0;  end
        endcase
        flags_n.n = res_n[DATA_W-1];
        flags_n.z = (res_n == '0);
        flags_n.c = amt_zero ? c_in_i : cout_n;
        flags_n.v = 1'b0;
    end

    assign upd  = in_valid_i & ~range_err;
    assign errv = in_valid_i &  range_err;

    generate
        if (OUT_REG) begin : g_reg
            logic [DATA_W-1:0] res_q;
            shf_flags_t        flags_q;
            logic              wr_q, err_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q   <= '0;
                    flags_q <= '0;
                    wr_q    <= 1'b0;
                    err_q   <= 1'b0;
                end else begin
                    wr_q  <= upd;
                    err_q <= errv;
                    if (upd) begin
                        res_q   <= res_n;
                        flags_q <= flags_n;
                    end
                end
            end

            assign res_o = res_q;
            assign n_o   = flags_q.n;
            assign z_o   = flags_q.z;
            assign c_o   = flags_q.c;
            assign v_o   = flags_q.v;
            assign wr_o  = wr_q;
            assign err_o = err_q;
        end else begin : g_comb
            assign res_o = upd ? res_n     : '0;
            assign n_o   = upd ? flags_n.n : 1'b0;
            assign z_o   = upd ? flags_n.z : 1'b0;
            assign c_o   = upd ? flags_n.c : c_in_i;
            assign v_o   = 1'b0;
            assign wr_o  = upd;
            assign err_o = errv;
        end
    endgenerate
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic [1:0]        op_i,
    input logic              amt_sel_i,
    input logic [AMT_W-1:0]  amt_reg_i,
    input logic [SH_W-1:0]   amt_imm_i,
    input logic              c_in_i,
    input logic [DATA_W-1:0] res_o,
    input logic              n_o,
    input logic              z_o,
    input logic              c_o,
    input logic              err_o,
    input logic              wr_o
);
    localparam logic [AMT_W-1:0] LSL_LIM = AMT_W'(DATA_W - 1);
    localparam logic [AMT_W-1:0] ASR_LIM = AMT_W'(DATA_W);

    logic zero_amt, lsl_bad, asr_bad;
    assign zero_amt = amt_sel_i ? (amt_reg_i == '0) : (amt_imm_i == '0);
    assign lsl_bad  = in_valid_i && amt_sel_i && op_i == 2'd0 && amt_reg_i > LSL_LIM;
    assign asr_bad  = in_valid_i && amt_sel_i && op_i == 2'd1 && amt_reg_i > ASR_LIM;

    a_r8_no_commit_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && wr_o));

    a_r5_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (n_o == res_o[DATA_W-1]) && (z_o == (res_o == '0)));

    generate
        if (OUT_REG) begin : g_reg_chk
            a_r6_lsl_range: assert property (@(posedge clk) disable iff (!rst_n)
                lsl_bad |=> err_o);
            a_r6_asr_range: assert property (@(posedge clk) disable iff (!rst_n)
                asr_bad |=> err_o);
            a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid_i && op_i == 2'd3) |=> err_o);
            a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
                err_o |-> ($stable(res_o) && $stable(c_o) && $stable(n_o)));
            a_r4_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid_i && zero_amt && op_i != 2'd3) |=> (wr_o && c_o == $past(c_in_i)));
            a_r9_wr_from_req: assert property (@(posedge clk) disable iff (!rst_n)
                wr_o |-> $past(in_valid_i));
        end else begin : g_comb_chk
            a_r6_range_now: assert property (@(posedge clk) disable iff (!rst_n)
                (lsl_bad || asr_bad) |-> err_o);
            a_r7_reserved_now: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid_i && op_i == 2'd3) |-> err_o);
            a_r4_keep_carry_now: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid_i && zero_amt && op_i != 2'd3) |-> (wr_o && c_o == c_in_i));
            a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid_i |-> (!wr_o && !err_o && c_o == c_in_i));
        end
    endgenerate
endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W(DATA_W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
    .amt_sel_i(amt_sel_i), .amt_reg_i(amt_reg_i), .amt_imm_i(amt_imm_i),
    .c_in_i(c_in_i), .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o),
    .err_o(err_o), .wr_o(wr_o)
);

// File: tb/shf_unit_tb.sv
module shf_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        sel = 1'b0;
    logic [7:0]  amt_reg = '0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] opnd = '0;
    logic        cin = 1'b0;

    logic [31:0] r_res, c_res;
    logic r_n, r_z, r_c, r_v, r_err, r_wr;
    logic c_n, c_z, c_c, c_v, c_err, c_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected state of the registered outputs
    logic [31:0] e_res = '0;
    logic e_n = 0, e_z = 0, e_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shf_unit #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op),
        .amt_sel_i(sel), .amt_reg_i(amt_reg), .amt_imm_i(amt_imm),
        .opnd_i(opnd), .c_in_i(cin), .res_o(r_res), .n_o(r_n), .z_o(r_z),
        .c_o(r_c), .v_o(r_v), .err_o(r_err), .wr_o(r_wr));

    shf_unit #(.OUT_REG(1'b0)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op),
        .amt_sel_i(sel), .amt_reg_i(amt_reg), .amt_imm_i(amt_imm),
        .opnd_i(opnd), .c_in_i(cin), .res_o(c_res), .n_o(c_n), .z_o(c_z),
        .c_o(c_c), .v_o(c_v), .err_o(c_err), .wr_o(c_wr));

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // bit-serial reference model
    task automatic model(input logic [1:0] m_op, input bit m_sel, input int m_amt,
                         input logic [31:0] a, input bit m_cin,
                         output logic [31:0] r, output bit c, output bit e);
        e = (m_op == 2'd3) || (m_sel && m_op == 2'd0 && m_amt > 31) ||
            (m_sel && m_op == 2'd1 && m_amt > 32);
        r = a;
        c = m_cin;
        for (int i = 0; i < m_amt; i++) begin
            case (m_op)
                2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'd1: begin c = r[0];  r = {r[31], r[31:1]}; end
                2'd2: begin c = r[0];  r = {r[0], r[31:1]}; end
                default: ;
            endcase
        end
        if (m_op == 2'd3) r = '0;
    endtask

    task automatic do_op(input logic [1:0] t_op, input bit t_sel, input int t_amt,
                         input logic [31:0] a, input bit t_cin, input string tag);
        logic [31:0] xr;
        bit xc, xe;
        model(t_op, t_sel, t_amt, a, t_cin, xr, xc, xe);
        @(negedge clk);
        op = t_op; sel = t_sel; amt_reg = t_amt[7:0]; amt_imm = t_amt[4:0];
        opnd = a; cin = t_cin; in_valid = 1'b1;
        #1;
        // R9 same-cycle variant
        chk(tag, "comb err", {31'd0, c_err}, {31'd0, xe});
        chk(tag, "comb wr R9", {31'd0, c_wr}, {31'd0, !xe});
        chk(tag, "comb res", c_res, xe ? 32'd0 : xr);
        chk(tag, "comb c", {31'd0, c_c}, {31'd0, xe ? t_cin : xc});
        chk("R5", "comb v", {31'd0, c_v}, 32'd0);
        if (!xe) begin
            e_res = xr; e_c = xc; e_n = xr[31]; e_z = (xr == 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, "reg err", {31'd0, r_err}, {31'd0, xe});
        chk(xe ? "R8" : "R9", "reg wr", {31'd0, r_wr}, {31'd0, !xe});
        chk(xe ? "R8" : tag, "reg res", r_res, e_res);
        chk(xe ? "R8" : tag, "reg c", {31'd0, r_c}, {31'd0, e_c});
        chk("R5", "reg n", {31'd0, r_n}, {31'd0, e_n});
        chk("R5", "reg z", {31'd0, r_z}, {31'd0, e_z});
        chk("R5", "reg v", {31'd0, r_v}, 32'd0);
    endtask

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0: return 32'h8000_0001;
            1: return 32'h7FFF_FFFF;
            2: return 32'hC35A_00F0;
            3: return 32'h0000_0000;
            default: return $urandom;
        endcase
    endfunction

    task automatic t_reset();
        chk("R10", "res", r_res, 32'd0);
        chk("R10", "flags", {28'd0, r_n, r_z, r_c, r_v}, 32'd0);
        chk("R10", "wr/err", {30'd0, r_wr, r_err}, 32'd0);
    endtask

    task automatic t_lsl_sweep();
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a = pattern(k);
            for (int s = 0; s <= 33; s++)
                do_op(2'd0, 1'b1, s, a, s[0], s == 0 ? "R4" : (s > 31 ? "R6" : "R1"));
        end
    endtask

    task automatic t_asr_sweep();
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a = pattern(k);
            for (int s = 0; s <= 33; s++)
                do_op(2'd1, 1'b1, s, a, ~s[0], s == 0 ? "R4" : (s > 32 ? "R6" : "R2"));
        end
    endtask

    task automatic t_ror_sweep();
        for (int k = 0; k < 6; k++) begin
            logic [31:0] a = pattern(k);
            for (int s = 0; s <= 33; s++)
                do_op(2'd2, 1'b1, s, a, s[1], s == 0 ? "R4" : "R3");
        end
        // R3 large multiples and wrap of the modulo
        do_op(2'd2, 1'b1, 64, 32'h8000_0000, 1'b0, "R3");
        do_op(2'd2, 1'b1, 64, 32'h0000_0001, 1'b1, "R3");
        do_op(2'd2, 1'b1, 200, 32'h1234_5678, 1'b0, "R3");
    endtask

    task automatic t_imm_paths();
        // R6 immediate amounts never raise the error
        for (int s = 0; s < 32; s++) begin
            do_op(2'd0, 1'b0, s, 32'hF00F_1234, 1'b1, "R6");
            do_op(2'd1, 1'b0, s, 32'h8765_4321, 1'b0, "R6");
        end
    endtask

    task automatic t_err_hold();
        do_op(2'd0, 1'b1, 4, 32'h0000_00FF, 1'b0, "R1");
        do_op(2'd0, 1'b1, 200, 32'hFFFF_FFFF, 1'b1, "R8");
        do_op(2'd1, 1'b1, 40, 32'h8000_0000, 1'b0, "R8");
    endtask

    task automatic t_reserved();
        do_op(2'd3, 1'b0, 3, 32'h1111_1111, 1'b1, "R7");
        do_op(2'd3, 1'b1, 0, 32'h2222_2222, 1'b0, "R7");
    endtask

    task automatic t_idle();
        // R9 commit lasts one cycle; idle cycles raise nothing
        do_op(2'd2, 1'b0, 8, 32'hABCD_EF01, 1'b0, "R3");
        @(negedge clk);
        chk("R9", "wr after idle", {31'd0, r_wr}, 32'd0);
        chk("R9", "res held idle", r_res, e_res);
        chk("R9", "comb wr idle", {31'd0, c_wr}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lsl_sweep();
        t_asr_sweep();
        t_ror_sweep();
        t_imm_paths();
        t_err_hold();
        t_reserved();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule